// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host controller read and write a small bank of control registers, and read a set of status registers, in a multi-channel switch controller over a four-wire serial link. The host lowers an active-low select and clocks a 16-bit frame in, most significant bit first. The first byte holds a chip address, a 5-bit command code and a parity bit. The second byte holds write data. While the frame is clocked in, the block sends a verification byte followed by read data.

All serial inputs are brought into the system clock domain and their edges are detected there. The system clock must run at least four times faster than the serial clock. Several slaves may share one select line, and each one answers only to its own chip address. A write lands only when the frame has exactly 16 clocks, the address matches, the parity is correct and the code is valid. A bad frame sets a sticky error flag. The host sees that flag in the verification byte of its next addressed frame.

Top module: `spi_regslave`

## Requirements
- R1: A frame is sent MSB first and SI is sampled on each falling edge of SCK. In the first byte, bits 7:6 are the chip address, bits 5:1 are the command code and bit 0 is the parity bit. The second byte is the write data.
- R2: A write is applied only when select rises after exactly 16 SCK falling edges, with a matching address, correct parity and a valid write code.
- R3: Command codes 01h..05h write control register 0..4. Codes 09h..0Dh read control register 0..4. Codes 11h..15h read status register 0..4. Every other code is invalid.
- R4: Parity is odd: the eight bits of the first byte must hold an odd number of ones. A parity mismatch is handled as an invalid code.
- R5: An addressed frame with an invalid code or bad parity changes no register and sets the error flag.
- R6: An addressed frame with 8 or more clocks but not exactly 16 discards its write and sets the error flag.
- R7: The error flag is sent as bit 7 of the verification byte. It is cleared only at the end of an addressed frame of 8 or more clocks that itself has no error.
- R8: A frame whose address differs from CHIP_ADDR writes nothing and leaves the error flag unchanged.
- R9: SO changes on each SCK rising edge. The first 8 bits are the verification byte {err, 0, CHIP_ADDR, 1010b}. The next 8 bits are the read data of a valid addressed read in the same frame, or 00h for any other frame.
- R10: After reset, control register 0 holds 80h, register 1 holds 00h, and registers 2..4 hold FFh. Status registers read FFh.
- R11: so_oe is low in the cycle after any cycle with rst high, and low while select is inactive. It is high while a frame is in progress.
- R12: A frame with fewer than 8 clocks has no effect on registers or on the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low slave select |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for SO; low means high impedance |
| regs_o | output | 8*NREG | Control register contents, register 0 in the low byte |

## Verification
On every cycle, the assertions check that the output enable drops after reset and while the block is deselected. They also check that a write strobe follows only the end of a 16-clock frame with odd parity, that the error flag falls only at the end of a frame, and that registers hold their value when no write is applied. Only the bench scenarios can show the rest: the exact verification and read bytes, the stickiness of the error flag across frames meant for other chips, the handling of short and long frames, and the register values that follow.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
  typedef enum logic [1:0] {OP_BAD, OP_WR, OP_RD, OP_RDS} op_e;

  typedef struct packed {
    op_e        op;
    logic [2:0] idx;
  } cmd_t;

  // code[4:3] selects the command group, code[2:0] is the register number plus one
  function automatic cmd_t decode_cmd(input logic [4:0] code, input int nreg, input int nsts);
    cmd_t c;
    c.op  = OP_BAD;
    c.idx = code[2:0] - 3'd1;
    if (code[2:0] != 3'd0) begin
      if (code[4:3] == 2'b00 && 32'(code[2:0]) <= nreg) c.op = OP_WR;
      else if (code[4:3] == 2'b01 && 32'(code[2:0]) <= nreg) c.op = OP_RD;
      else if (code[4:3] == 2'b10 && 32'(code[2:0]) <= nsts) c.op = OP_RDS;
    end
    return c;
  endfunction

  function automatic logic [7:0] ctrl_reset(input int i);
    if (i == 0) return 8'h80;
    if (i == 1) return 8'h00;
    return 8'hFF;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
    end else begin
      st[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regslave_pkg::*;
#(
  parameter logic [1:0] CHIP_ADDR = 2'b01,
  parameter int         NREG      = 5,
  parameter int         NSTS      = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_s,
  input  logic       si_s,
  input  logic       csn_s,
  input  logic [7:0] rd_byte_i,
  output cmd_t       cmd_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       so_o,
  output logic       so_oe_o
);
  localparam int CW = 5;
  localparam logic [CW-1:0] CMAX = '1;

  logic          sck_q, csn_q;
  logic [CW-1:0] fall_cnt, rise_cnt;
  logic [7:0]    hdr_q, dat_q, so_sh;
  logic          so_q, oe_q, err_q, wr_en_q;

  wire sel      = ~csn_s;
  wire sck_rise = sck_s & ~sck_q;
  wire sck_fall = ~sck_s & sck_q;
  wire cs_start = ~csn_s & csn_q;
  wire cs_end   = csn_s & ~csn_q;

  cmd_t cmd;
  logic have_hdr, addr_ok, code_ok, is_read;
  logic [7:0] verif, rd_v;

  always_comb begin
    cmd      = decode_cmd(hdr_q[5:1], NREG, NSTS);
    have_hdr = fall_cnt >= CW'(8);
    addr_ok  = hdr_q[7:6] == CHIP_ADDR;
    code_ok  = (^hdr_q) && (cmd.op != OP_BAD);
    is_read  = (cmd.op == OP_RD) || (cmd.op == OP_RDS);
    verif    = {err_q, 1'b0, CHIP_ADDR, 4'b1010};
    rd_v     = (addr_ok && code_ok && is_read) ? rd_byte_i : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      csn_q    <= 1'b1;
      fall_cnt <= '0;
      rise_cnt <= '0;
      hdr_q    <= '0;
      dat_q    <= '0;
      so_sh    <= '0;
      so_q     <= 1'b0;
      oe_q     <= 1'b0;
      err_q    <= 1'b0;
      wr_en_q  <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      csn_q   <= csn_s;
      oe_q    <= sel;
      wr_en_q <= 1'b0;
      if (cs_start) begin
        fall_cnt <= '0;
        rise_cnt <= '0;
        so_sh    <= verif;
        so_q     <= 1'b0;
      end else if (sel) begin
        if (sck_fall) begin
          if (fall_cnt != CMAX) fall_cnt <= fall_cnt + 1'b1;
          if (fall_cnt < CW'(8)) hdr_q <= {hdr_q[6:0], si_s};
          else                   dat_q <= {dat_q[6:0], si_s};
        end
        if (sck_rise) begin
          if (rise_cnt != CMAX) rise_cnt <= rise_cnt + 1'b1;
          if (rise_cnt == CW'(8)) begin
            so_q  <= rd_v[7];
            so_sh <= {rd_v[6:0], 1'b0};
          end else begin
            so_q  <= so_sh[7];
            so_sh <= {so_sh[6:0], 1'b0};
          end
        end
      end
      if (cs_end && have_hdr && addr_ok) begin
        err_q   <= ~code_ok | (fall_cnt != CW'(16));
        wr_en_q <= code_ok && (fall_cnt == CW'(16)) && (cmd.op == OP_WR);
      end
    end
  end

  assign cmd_o     = cmd;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = dat_q;
  assign so_o      = so_q;
  assign so_oe_o   = oe_q;

  AST_OE_AFTER_RST: assert property (@(posedge clk) rst |=> !oe_q); // R11
  AST_OE_DESELECTED: assert property (@(posedge clk) disable iff (rst) csn_s |=> !oe_q); // R11
  AST_WR_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> ($past(cs_end) && $past(fall_cnt) == CW'(16))); // R2
  AST_WR_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> ^$past(hdr_q)); // R4
  AST_ERR_CLEARS_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> $past(cs_end)); // R7
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_regslave_pkg::*;
#(
  parameter int         NREG    = 5,
  parameter logic [7:0] STS_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  cmd_t              cmd_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_byte_o,
  output logic [8*NREG-1:0] regs_o
);
  logic [7:0] ctrl [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                          ctrl[g] <= ctrl_reset(g);
      else if (wr_en_i && cmd_i.idx == 3'(g))           ctrl[g] <= wr_data_i;
    end
    assign regs_o[8*g +: 8] = ctrl[g];
  end

  always_comb begin
    case (cmd_i.op)
      OP_RD:   rd_byte_o = ctrl[cmd_i.idx];
      OP_RDS:  rd_byte_o = STS_VAL;
      default: rd_byte_o = 8'h00;
    endcase
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en_i) |-> $stable(regs_o)); // R5
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter logic [1:0] CHIP_ADDR   = 2'b01,
  parameter int         NREG        = 5,
  parameter int         NSTS        = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              si,
  input  logic              cs_n,
  output logic              so,
  output logic              so_oe,
  output logic [8*NREG-1:0] regs_o
);
  logic [2:0] pins_s;
  cmd_t       cmd;
  logic       wr_en;
  logic [7:0] wr_data, rd_byte;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(rst), .d_i({sck, si, cs_n}), .q_o(pins_s)
  );

  spi_frame #(.CHIP_ADDR(CHIP_ADDR), .NREG(NREG), .NSTS(NSTS)) u_frame (
    .clk(clk), .rst(rst),
    .sck_s(pins_s[2]), .si_s(pins_s[1]), .csn_s(pins_s[0]),
    .rd_byte_i(rd_byte), .cmd_o(cmd), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .so_o(so), .so_oe_o(so_oe)
  );

  spi_regbank #(.NREG(NREG), .STS_VAL(8'hFF)) u_bank (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .cmd_i(cmd), .wr_data_i(wr_data),
    .rd_byte_o(rd_byte), .regs_o(regs_o)
  );
endmodule

// File: tb/spi_regslave_tb.sv
module spi_regslave_tb;
  localparam int H = 10;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b1;
  logic so, so_oe;
  logic [39:0] regs_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_regslave u_dut (
    .clk(clk), .rst(rst), .sck(sck), .si(si), .cs_n(cs_n),
    .so(so), .so_oe(so_oe), .regs_o(regs_o)
  );

  // {addr, code, parity_ok, data, nbits, exp_err, exp_rd}
  localparam logic [29:0] VEC [NV] = '{
    {2'd1, 5'h09, 1'b1, 8'h00, 5'd16, 1'b0, 8'h80}, // R10 reset value reg0
    {2'd1, 5'h0A, 1'b1, 8'h00, 5'd16, 1'b0, 8'h00}, // R10 reg1
    {2'd1, 5'h0B, 1'b1, 8'h00, 5'd16, 1'b0, 8'hFF}, // R10 reg2
    {2'd1, 5'h11, 1'b1, 8'h00, 5'd16, 1'b0, 8'hFF}, // R3 status read
    {2'd1, 5'h01, 1'b1, 8'h3C, 5'd16, 1'b0, 8'h00}, // R2 write reg0
    {2'd1, 5'h09, 1'b1, 8'h00, 5'd16, 1'b0, 8'h3C}, // R2 readback
    {2'd2, 5'h02, 1'b1, 8'h5A, 5'd16, 1'b0, 8'h00}, // R8 other chip write
    {2'd1, 5'h0A, 1'b1, 8'h00, 5'd16, 1'b0, 8'h00}, // R8 reg1 untouched
    {2'd1, 5'h1F, 1'b1, 8'h77, 5'd16, 1'b0, 8'h00}, // R5 invalid code
    {2'd1, 5'h09, 1'b1, 8'h00, 5'd16, 1'b1, 8'h3C}, // R7 flag reported
    {2'd1, 5'h09, 1'b1, 8'h00, 5'd16, 1'b0, 8'h3C}, // R7 flag cleared
    {2'd1, 5'h03, 1'b0, 8'h11, 5'd16, 1'b0, 8'h00}, // R4 bad parity write
    {2'd1, 5'h0B, 1'b1, 8'h00, 5'd16, 1'b1, 8'hFF}, // R4 R5 not written, flag
    {2'd1, 5'h04, 1'b1, 8'h22, 5'd15, 1'b0, 8'h00}, // R6 15-clock write
    {2'd1, 5'h0C, 1'b1, 8'h00, 5'd16, 1'b1, 8'hFF}, // R6 discarded, flag
    {2'd1, 5'h05, 1'b1, 8'h33, 5'd17, 1'b0, 8'h00}, // R6 17-clock write
    {2'd2, 5'h0D, 1'b1, 8'h00, 5'd16, 1'b1, 8'h00}, // R8 flag kept
    {2'd1, 5'h0D, 1'b1, 8'h00, 5'd16, 1'b1, 8'hFF}, // R7 still set
    {2'd1, 5'h01, 1'b1, 8'h99, 5'd5,  1'b0, 8'h00}, // R12 short frame
    {2'd1, 5'h09, 1'b1, 8'h00, 5'd16, 1'b0, 8'h3C}, // R12 no effect
    {2'd1, 5'h05, 1'b1, 8'hA5, 5'd16, 1'b0, 8'h00}, // R3 write reg4
    {2'd1, 5'h0D, 1'b1, 8'h00, 5'd16, 1'b0, 8'hA5}  // R3 read reg4
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] a, input logic [4:0] code, input logic pok,
                           input logic [7:0] d, input int nb,
                           output logic [15:0] cap, output logic oe_seen);
    logic [6:0]  h;
    logic [15:0] w;
    h = {a, code};
    w = {h, (pok ? ~^h : ^h), d};
    cap = '0;
    oe_seen = 1'b0;
    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nb; i++) begin
      si  = (i < 16) ? w[15-i] : 1'b0;
      sck = 1'b1;
      wait_clk(H - 1);
      if (i < 16) cap[15-i] = so;
      if (i == 0) oe_seen = so_oe;
      wait_clk(1);
      sck = 1'b0;
      wait_clk(H);
    end
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] cap;
    logic        oe;
    wait_clk(5);
    check("R11 oe during reset", so_oe, 1'b0);
    rst = 1'b0;
    wait_clk(5);
    check("R11 oe while deselected", so_oe, 1'b0);
    check("R10 reset register values", regs_o, 40'hFF_FF_FF_00_80);

    for (int v = 0; v < NV; v++) begin
      int nb;
      nb = int'(VEC[v][13:9]);
      run_frame(VEC[v][29:28], VEC[v][27:23], VEC[v][22], VEC[v][21:14], nb, cap, oe);
      check($sformatf("R11 oe in frame %0d", v), oe, 1'b1);
      if (nb >= 8)
        check($sformatf("R1 R7 R9 verification byte frame %0d", v), cap[15:8],
              VEC[v][8] ? 8'h9A : 8'h1A);
      else
        check($sformatf("R7 R12 error bit frame %0d", v), cap[15], VEC[v][8]);
      if (nb >= 16)
        check($sformatf("R3 R9 read data frame %0d", v), cap[7:0], VEC[v][7:0]);
    end
    check("R2 R5 R6 R8 final registers", regs_o, 40'hA5_FF_FF_00_3C);
    check("R11 oe after frames", so_oe, 1'b0);

    // set the error flag, then reset in the middle of a frame
    run_frame(2'd1, 5'h1E, 1'b1, 8'h00, 16, cap, oe);
    cs_n = 1'b0;
    wait_clk(H);
    sck = 1'b1;
    wait_clk(H);
    rst = 1'b1;
    wait_clk(2);
    check("R11 oe low after reset mid-frame", so_oe, 1'b0);
    cs_n = 1'b1;
    sck  = 1'b0;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(5);
    check("R10 registers after second reset", regs_o, 40'hFF_FF_FF_00_80);
    run_frame(2'd1, 5'h09, 1'b1, 8'h00, 16, cap, oe);
    check("R7 R10 flag cleared by reset", cap[15:8], 8'h1A);
    check("R10 reg0 read after reset", cap[7:0], 8'h80);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule